// File: doc/BRIEF.md
# Serial Disk Field CRC-16 Engine

This block keeps a 16-bit cyclic redundancy code over a serial bit stream. It is used for the identifier and data fields of a disk track, one bit at a time. The code is loaded with all ones just before the first address mark byte, so the address marks are covered along with the payload. The generator polynomial is x^16 + x^12 + x^5 + 1. Bits enter most significant bit first, with one bit per strobe.

On the write side, the engine sits in generate mode and passes the field bits through to its serial output. A transmit request then makes it shift its own two check bytes out behind the field, most significant bit first. On the read side, the engine sits in check mode and takes in the field and the two recorded check bytes. An end-of-field strobe then latches an error flag, which is set when the remaining value is not zero. Address-mark detection, byte framing and clock recovery belong to neighbouring blocks.

Top module: `crc16_field_engine`

## Requirements
- R1: After reset, `crc_o` is 0xFFFF, `busy_o` is 0 and `crc_err_o` is 0.
- R2: A `preset_i` pulse loads 0xFFFF into the code register and ends any emission in progress. Preset wins over a `bit_vld_i`, `emit_i` or `field_end_i` that arrives in the same cycle.
- R3: Each `bit_vld_i` strobe outside an emission updates the register at the next edge. With f = `bit_i` XOR crc[15], the new value is (crc << 1) XOR (f ? 0x1021 : 0). For example, the ASCII string "123456789" fed MSB first gives 0x29B1.
- R4: In a cycle with no `preset_i` and no `bit_vld_i`, `crc_o` keeps its value.
- R5: While `gen_mode_i` = 1 (generate) and the block is idle, `emit_i` raises `busy_o` at the next edge. During the emission, `ser_o` shows crc[15], and each strobe shifts the register left with a zero filling bit 0. `bit_i` has no effect. After exactly 16 strobes, `busy_o` falls and `crc_o` is 0.
- R6: `emit_i` has no effect when `gen_mode_i` = 0 (check), and it does not restart an emission that is already running.
- R7: With `gen_mode_i` = 0, a `field_end_i` pulse makes `crc_err_o` equal to (`crc_o` != 0) from the next edge. The flag holds until the next preset or verdict. A field followed by its correct check bytes gives 0, and any single flipped bit gives 1.
- R8: Outside an emission, `ser_o` equals `bit_i`. The write stream is therefore the field followed by its check bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| preset_i | input | 1 | Load all ones, cancel emission, clear verdict |
| bit_vld_i | input | 1 | One serial bit period |
| bit_i | input | 1 | Serial data bit, MSB of each byte first |
| gen_mode_i | input | 1 | 1 = generate (write), 0 = check (read) |
| emit_i | input | 1 | Request to shift the code out (generate mode) |
| field_end_i | input | 1 | Latch the check verdict (check mode) |
| ser_o | output | 1 | Serial write stream |
| busy_o | output | 1 | Code emission in progress |
| crc_o | output | 16 | Current code register |
| crc_err_o | output | 1 | Latched check verdict |

## Verification
The hardest case to reach is a verdict taken on a field whose stored check bytes differ from the computed code in just one bit. This can only happen after the engine has taken in a whole field. The bench builds an identifier field and appends check bytes computed by its own arithmetic model. It then replays the field once for every bit position with that bit inverted, and expects an error each time and none on the clean replay. Emission is also run with the request held high and with noisy data bits, to show that neither a restart nor a data bit disturbs the 16-bit tail.

// File: rtl/crc16_field_pkg.sv
package crc16_field_pkg;
   typedef enum logic {
      MODE_CHECK = 1'b0,
      MODE_GEN   = 1'b1
   } crc_mode_e;

   localparam int unsigned DEF_W    = 16;
   localparam logic [15:0] DEF_POLY = 16'h1021;
   localparam logic [15:0] DEF_INIT = 16'hFFFF;
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
   parameter int unsigned     W    = 16,
   parameter logic [W-1:0]    POLY = 16'h1021
) (
   input  logic [W-1:0] cur_i,
   input  logic         din_i,
   output logic [W-1:0] nxt_o
);
   logic fb;
   assign fb = din_i ^ cur_i[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         if (POLY[0]) begin : g_x
            assign nxt_o[0] = fb;
         end else begin : g_z
            assign nxt_o[0] = 1'b0;
         end
      end else begin : g_up
         if (POLY[i]) begin : g_x
            assign nxt_o[i] = cur_i[i-1] ^ fb;
         end else begin : g_p
            assign nxt_o[i] = cur_i[i-1];
         end
      end
   end
endmodule

// File: rtl/crc_shift_reg.sv
module crc_shift_reg #(
   parameter int unsigned  W    = 16,
   parameter logic [W-1:0] INIT = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         preset_i,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o <= INIT;
      else if (preset_i) q_o <= INIT;
      else if (load_i)   q_o <= d_i;
   end
endmodule

// File: rtl/crc_emit_ctrl.sv
module crc_emit_ctrl #(
   parameter int unsigned W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic preset_i,
   input  logic start_i,
   input  logic step_i,
   output logic busy_o
);
   localparam int unsigned CW = $clog2(W + 1);
   localparam logic [CW-1:0] FULL = CW'(W);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 left_q <= '0;
      else if (preset_i)          left_q <= '0;
      else if (busy_o && step_i)  left_q <= left_q - 1'b1;
      else if (start_i)           left_q <= FULL;
   end

   assign busy_o = (left_q != '0);
endmodule

// File: rtl/crc_verdict.sv
module crc_verdict #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         preset_i,
   input  logic         take_i,
   input  logic [W-1:0] rem_i,
   output logic         err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_o <= 1'b0;
      else if (preset_i) err_o <= 1'b0;
      else if (take_i)   err_o <= (rem_i != '0);
   end
endmodule

// File: rtl/crc16_field_engine.sv
module crc16_field_engine
   import crc16_field_pkg::*;
#(
   parameter int unsigned     CRC_W    = DEF_W,
   parameter logic [CRC_W-1:0] CRC_POLY = DEF_POLY,
   parameter logic [CRC_W-1:0] CRC_INIT = DEF_INIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             preset_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic             gen_mode_i,
   input  logic             emit_i,
   input  logic             field_end_i,
   output logic             ser_o,
   output logic             busy_o,
   output logic [CRC_W-1:0] crc_o,
   output logic             crc_err_o
);
   if (CRC_W < 8) begin : g_bad_width
      $error("crc16_field_engine: CRC_W must be at least 8");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc16_field_engine: CRC_POLY must have its constant term set");
   end

   crc_mode_e      mode;
   logic [CRC_W-1:0] step_nxt;
   logic [CRC_W-1:0] tail_nxt;
   logic [CRC_W-1:0] reg_d;
   logic           emit_go;
   logic           take_verdict;

   assign mode         = crc_mode_e'(gen_mode_i);
   assign emit_go      = emit_i && (mode == MODE_GEN) && !busy_o;
   assign take_verdict = field_end_i && (mode == MODE_CHECK);
   assign tail_nxt     = {crc_o[CRC_W-2:0], 1'b0};
   assign reg_d        = busy_o ? tail_nxt : step_nxt;
   assign ser_o        = busy_o ? crc_o[CRC_W-1] : bit_i;

   crc_bit_step #(.W(CRC_W), .POLY(CRC_POLY)) u_step (
      .cur_i (crc_o),
      .din_i (bit_i),
      .nxt_o (step_nxt)
   );

   crc_shift_reg #(.W(CRC_W), .INIT(CRC_INIT)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .preset_i (preset_i),
      .load_i   (bit_vld_i),
      .d_i      (reg_d),
      .q_o      (crc_o)
   );

   crc_emit_ctrl #(.W(CRC_W)) u_emit (
      .clk      (clk),
      .rst_n    (rst_n),
      .preset_i (preset_i),
      .start_i  (emit_go),
      .step_i   (bit_vld_i),
      .busy_o   (busy_o)
   );

   crc_verdict #(.W(CRC_W)) u_verdict (
      .clk      (clk),
      .rst_n    (rst_n),
      .preset_i (preset_i),
      .take_i   (take_verdict),
      .rem_i    (crc_o),
      .err_o    (crc_err_o)
   );
endmodule

// File: rtl/crc16_field_engine_chk.sv
module crc16_field_engine_chk #(
   parameter int unsigned      CRC_W    = 16,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             preset_i,
   input logic             bit_vld_i,
   input logic             bit_i,
   input logic             gen_mode_i,
   input logic             emit_i,
   input logic             field_end_i,
   input logic             ser_o,
   input logic             busy_o,
   input logic [CRC_W-1:0] crc_o,
   input logic             crc_err_o
);
   // R2: preset loads the initial value whatever else is strobed
   a_r2_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      preset_i |=> (crc_o == CRC_INIT) && !busy_o && !crc_err_o);

   // R4: no strobe, no change
   a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!preset_i && !bit_vld_i) |=> $stable(crc_o));

   // R5: a request in generate mode while idle starts an emission
   a_r5_emit_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (emit_i && gen_mode_i && !busy_o && !preset_i) |=> busy_o);

   // R5: the emitted tail fills with zeros
   a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && bit_vld_i && !preset_i) |=> (crc_o[0] == 1'b0));

   // R5: a completed emission leaves a zero register
   a_r5_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(preset_i)) |-> (crc_o == '0));

   // R6: check mode never starts an emission
   a_r6_no_emit_check: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !gen_mode_i) |=> !busy_o);

   // R7: verdict reflects the remainder at the strobe
   a_r7_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (field_end_i && !gen_mode_i && !preset_i) |=> (crc_err_o == ($past(crc_o) != '0)));

   // R8: passthrough outside emission
   a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (ser_o == bit_i));
endmodule

bind crc16_field_engine crc16_field_engine_chk #(.CRC_W(CRC_W), .CRC_INIT(CRC_INIT)) u_chk (.*);

// File: tb/crc16_field_engine_bench.sv
`timescale 1ns/1ps
module crc16_field_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        preset_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
   logic        gen_mode_i = 1'b1, emit_i = 1'b0, field_end_i = 1'b0;
   logic        ser_o, busy_o, crc_err_o;
   logic [15:0] crc_o;

   int unsigned n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   crc16_field_engine u_crc16_field_engine (.*);

   function automatic logic [15:0] upd_bit(logic [15:0] c, logic b);
      logic f = b ^ c[15];
      return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
   endfunction

   function automatic logic [15:0] upd_byte(logic [15:0] c, logic [7:0] v);
      logic [15:0] r = c;
      for (int k = 7; k >= 0; k--) r = upd_bit(r, v[k]);
      return r;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_preset();
      @(negedge clk); preset_i = 1'b1;
      @(negedge clk); preset_i = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] v);
      for (int k = 7; k >= 0; k--) begin
         @(negedge clk); bit_vld_i = 1'b1; bit_i = v[k];
      end
      @(negedge clk); bit_vld_i = 1'b0;
   endtask

   task automatic verdict();
      @(negedge clk); field_end_i = 1'b1;
      @(negedge clk); field_end_i = 1'b0;
   endtask

   logic [7:0]  fld [10];
   logic [15:0] m;
   logic [15:0] got;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(crc_o == 16'hFFFF, "R1 crc", crc_o, 32'hFFFF);
      check(!busy_o && !crc_err_o, "R1 flags", {busy_o, crc_err_o}, 0);

      // R3 standard vector
      begin
         string s = "123456789";
         gen_mode_i = 1'b1;
         do_preset();
         for (int i = 0; i < 9; i++) send_byte(s[i]);
         check(crc_o == 16'h29B1, "R3 vector", crc_o, 32'h29B1);
      end

      // R3 exhaustive single byte sweep
      for (int v = 0; v < 256; v++) begin
         do_preset();
         send_byte(8'(v));
         m = upd_byte(16'hFFFF, 8'(v));
         check(crc_o == m, "R3 byte sweep", crc_o, m);
      end

      // R4 hold with no strobe
      m = crc_o;
      repeat (5) @(negedge clk);
      check(crc_o == m, "R4 hold", crc_o, m);

      // R2 preset beats a coincident strobe
      @(negedge clk); preset_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1;
      @(negedge clk); preset_i = 1'b0; bit_vld_i = 1'b0;
      check(crc_o == 16'hFFFF, "R2 preset priority", crc_o, 32'hFFFF);

      // Build an ID field: address marks, track, side, sector, size
      fld[0] = 8'hA1; fld[1] = 8'hA1; fld[2] = 8'hA1; fld[3] = 8'hFE;
      fld[4] = 8'h27; fld[5] = 8'h01; fld[6] = 8'h0A; fld[7] = 8'h02;
      m = 16'hFFFF;
      for (int i = 0; i < 8; i++) m = upd_byte(m, fld[i]);
      fld[8] = m[15:8]; fld[9] = m[7:0];

      // R8 passthrough and R5 emission with noisy data bits, emit held high (R6)
      gen_mode_i = 1'b1;
      do_preset();
      for (int i = 0; i < 8; i++) begin
         for (int k = 7; k >= 0; k--) begin
            @(negedge clk); bit_vld_i = 1'b1; bit_i = fld[i][k];
            #1 if (i == 4) check(ser_o == fld[i][k], "R8 passthrough", ser_o, fld[i][k]);
         end
      end
      @(negedge clk); bit_vld_i = 1'b0;
      check(crc_o == m, "R3 id field", crc_o, m);
      emit_i = 1'b1;
      @(negedge clk);
      check(busy_o, "R5 busy rises", busy_o, 1);
      got = '0;
      for (int k = 0; k < 16; k++) begin
         if (k == 15) check(busy_o, "R5 busy before last", busy_o, 1);
         bit_vld_i = 1'b1; bit_i = k[0];
         #1 got = {got[14:0], ser_o};
         @(negedge clk);
      end
      bit_vld_i = 1'b0;
      check(got == m, "R5 emitted code", got, m);
      check(!busy_o, "R6 no restart, R5 busy falls", busy_o, 0);
      check(crc_o == 16'h0000, "R5 zero after emit", crc_o, 0);
      emit_i = 1'b0;

      // R2 preset cancels emission
      @(negedge clk); emit_i = 1'b1;
      @(negedge clk); emit_i = 1'b0; preset_i = 1'b1;
      @(negedge clk); preset_i = 1'b0;
      check(!busy_o && crc_o == 16'hFFFF, "R2 cancel emission", {busy_o, crc_o}, 32'hFFFF);

      // R6 emit ignored in check mode
      gen_mode_i = 1'b0;
      @(negedge clk); emit_i = 1'b1;
      @(negedge clk); emit_i = 1'b0;
      check(!busy_o, "R6 check mode emit", busy_o, 0);

      // R7 clean field gives no error
      do_preset();
      for (int i = 0; i < 10; i++) send_byte(fld[i]);
      verdict();
      check(!crc_err_o, "R7 clean field", crc_err_o, 0);

      // R7 every single-bit corruption is flagged
      for (int p = 0; p < 80; p++) begin
         do_preset();
         for (int i = 0; i < 10; i++)
            send_byte(fld[i] ^ ((p / 8 == i) ? (8'h80 >> (p % 8)) : 8'h00));
         verdict();
         check(crc_err_o, "R7 corrupted bit", crc_err_o, 1);
      end

      // R7 flag holds, R2 preset clears it
      repeat (3) @(negedge clk);
      check(crc_err_o, "R7 holds", crc_err_o, 1);
      do_preset();
      check(!crc_err_o, "R2 clears verdict", crc_err_o, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule